// File: doc/BRIEF.md
# Interrupt Event Latch Aggregator

This block collects interrupt events from two groups of peripheral channels and turns them into three interrupt lines for a processor. The wide group (32 channels by default) is split by a per-channel priority map into a high-priority latch register and a low-priority latch register. The narrow group (14 channels by default) has one latch register of its own. Each latch register drives one interrupt output, which is the OR of its bits after a per-group enable mask.

Software finds the sources by reading the latch registers through a simple synchronous register port. In the default read-to-clear mode a read returns the register and clears its edge-latched bits in the same clock edge. An event detected in that same cycle still ends up set and is not lost. One channel of the wide group can be a level-type source, for example a FIFO fill-threshold flag. Its bit shows the present input level and neither a read nor a write clears it. A control bit switches the latches to write-1-to-clear handling instead. Software must then acknowledge each bit explicitly, or the interrupt stays asserted.

The register port has no back-pressure. A read or write is taken in the cycle its strobe is high, and read data appears on `bus_rdata` one cycle later.

Top module: `irq_latch_agg`

## Requirements
- R1: After reset, all latch registers, the priority map (address 3), both masks (addresses 4 and 5) and the control register (address 6) read 0, and all three interrupt outputs are low.
- R2: A rising edge on an edge-type wide-group channel i sets bit i of the high latch (address 0) when priority-map bit i is 1, and bit i of the low latch (address 1) when it is 0. An input that stays high does not set the bit again after it has been cleared.
- R3: In read-to-clear mode, a read of address 0 returns the high latch and clears only its edge bits. A read of address 1 does the same for the low latch only.
- R4: A narrow-group rising edge on channel j sets bit j of address 2. A read of address 2 returns the latch in bits 13:0, with the upper bits zero, and clears it in read-to-clear mode.
- R5: An edge detected in the same cycle as a clearing read or write of its register is kept set. It does not appear in that read's data.
- R6: Wide-group channel LVL_IDX (default 31) is level-type. Its bit, in the register chosen by its priority bit, equals the current input and is never cleared by a read or a write.
- R7: When control bit 0 is 1 (write-1-to-clear), reads do not clear the latches, and writing a 1 to a bit of address 0, 1 or 2 clears that bit only. When control bit 0 is 0, writes to addresses 0 to 2 have no effect.
- R8: `irq_hi` and `irq_lo` are the OR of their latch register ANDed with mask A (address 4). `irq_grp` is the OR of the narrow latch ANDed with mask B (address 5, bits 13:0).
- R9: A read of addresses 3 to 6 returns the stored value one cycle after the read strobe. Mask B keeps only bits 13:0 and the control register keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_a | input | 32 | Wide-group channel inputs |
| evt_b | input | 14 | Narrow-group channel inputs |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_hi | output | 1 | High-priority interrupt |
| irq_lo | output | 1 | Low-priority interrupt |
| irq_grp | output | 1 | Narrow-group interrupt |

## Verification
The bench builds the block with its default parameters: 32 wide-group channels, 14 narrow-group channels and the level source on channel 31. With these values, bits at both ends of the wide register and the top bit of the narrow register are reached. The level bit sits at the register's most significant position, so a read-back that lost it would show up. The full-width priority map and masks also let one run move channels between the high and low latches and switch between the two clearing modes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [2:0] {
    REG_HI   = 3'd0,
    REG_LO   = 3'd1,
    REG_GB   = 3'd2,
    REG_PRIO = 3'd3,
    REG_MSKA = 3'd4,
    REG_MSKB = 3'd5,
    REG_CTRL = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int W       = 32,
  parameter bit HAS_LVL = 1'b0,
  parameter int LVL_IDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] route,
  input  logic [W-1:0] clr,
  output logic [W-1:0] view
);
  localparam logic [W-1:0] LVL_MASK = HAS_LVL ? (W'(1) << LVL_IDX) : '0;

  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] set_v;

  assign set_v = evt & ~prev_q & route & ~LVL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= evt;
      lat_q  <= (lat_q & ~clr) | set_v;
    end
  end

  assign view = (lat_q & ~LVL_MASK) | (evt & route & LVL_MASK);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int NA = 32,
  parameter int NB = 14,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [NA-1:0] prio,
  output logic [NA-1:0] mask_a,
  output logic [NB-1:0] mask_b,
  output logic          w1c
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio   <= '0;
      mask_a <= '0;
      mask_b <= '0;
      w1c    <= 1'b0;
    end else if (wr) begin
      case (addr)
        REG_PRIO: prio   <= wdata[NA-1:0];
        REG_MSKA: mask_a <= wdata[NA-1:0];
        REG_MSKB: mask_b <= wdata[NB-1:0];
        REG_CTRL: w1c    <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_access_ctl.sv
module irq_access_ctl
  import irq_agg_pkg::*;
#(
  parameter int NA = 32,
  parameter int NB = 14,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          w1c,
  input  logic [NA-1:0] hi_view,
  input  logic [NA-1:0] lo_view,
  input  logic [NB-1:0] b_view,
  input  logic [NA-1:0] prio,
  input  logic [NA-1:0] mask_a,
  input  logic [NB-1:0] mask_b,
  output logic [NA-1:0] clr_hi,
  output logic [NA-1:0] clr_lo,
  output logic [NB-1:0] clr_b,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mux_v;

  function automatic logic [NA-1:0] clr_a(input logic [2:0] a, input reg_addr_e target,
                                          input logic r, input logic w, input logic m,
                                          input logic [DW-1:0] d);
    if (a != target)  return '0;
    if (m)            return w ? d[NA-1:0] : '0;
    return r ? '1 : '0;
  endfunction

  always_comb begin
    clr_hi = clr_a(addr, REG_HI, rd, wr, w1c, wdata);
    clr_lo = clr_a(addr, REG_LO, rd, wr, w1c, wdata);
    clr_b  = '0;
    if (addr == REG_GB) begin
      if (w1c) clr_b = wr ? wdata[NB-1:0] : '0;
      else     clr_b = rd ? '1 : '0;
    end
  end

  always_comb begin
    mux_v = '0;
    case (addr)
      REG_HI:   mux_v[NA-1:0] = hi_view;
      REG_LO:   mux_v[NA-1:0] = lo_view;
      REG_GB:   mux_v[NB-1:0] = b_view;
      REG_PRIO: mux_v[NA-1:0] = prio;
      REG_MSKA: mux_v[NA-1:0] = mask_a;
      REG_MSKB: mux_v[NB-1:0] = mask_b;
      REG_CTRL: mux_v[0]      = w1c;
      default:  mux_v         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= mux_v;
  end
endmodule

// File: rtl/irq_latch_agg.sv
module irq_latch_agg #(
  parameter int NA      = 32,
  parameter int NB      = 14,
  parameter int DW      = 32,
  parameter int LVL_IDX = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NA-1:0] evt_a,
  input  logic [NB-1:0] evt_b,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_hi,
  output logic          irq_lo,
  output logic          irq_grp
);
  logic [NA-1:0] prio, mask_a, hi_view, lo_view, clr_hi, clr_lo;
  logic [NB-1:0] mask_b, b_view, clr_b;
  logic          w1c;

  irq_cfg_regs #(.NA(NA), .NB(NB), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .prio(prio), .mask_a(mask_a), .mask_b(mask_b), .w1c(w1c)
  );

  irq_latch_bank #(.W(NA), .HAS_LVL(1'b1), .LVL_IDX(LVL_IDX)) u_hi (
    .clk(clk), .rst_n(rst_n), .evt(evt_a), .route(prio), .clr(clr_hi), .view(hi_view)
  );

  irq_latch_bank #(.W(NA), .HAS_LVL(1'b1), .LVL_IDX(LVL_IDX)) u_lo (
    .clk(clk), .rst_n(rst_n), .evt(evt_a), .route(~prio), .clr(clr_lo), .view(lo_view)
  );

  irq_latch_bank #(.W(NB), .HAS_LVL(1'b0), .LVL_IDX(0)) u_gb (
    .clk(clk), .rst_n(rst_n), .evt(evt_b), .route({NB{1'b1}}), .clr(clr_b), .view(b_view)
  );

  irq_access_ctl #(.NA(NA), .NB(NB), .DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .w1c(w1c), .hi_view(hi_view), .lo_view(lo_view),
    .b_view(b_view), .prio(prio), .mask_a(mask_a), .mask_b(mask_b),
    .clr_hi(clr_hi), .clr_lo(clr_lo), .clr_b(clr_b), .rdata(bus_rdata)
  );

  assign irq_hi  = |(hi_view & mask_a);
  assign irq_lo  = |(lo_view & mask_a);
  assign irq_grp = |(b_view & mask_b);
endmodule

// File: rtl/irq_latch_agg_chk.sv
module irq_latch_agg_chk #(
  parameter int NA      = 32,
  parameter int NB      = 14,
  parameter int DW      = 32,
  parameter int LVL_IDX = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NA-1:0] evt_a,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [NA-1:0] hi_view,
  input logic [NB-1:0] b_view,
  input logic [NA-1:0] prio,
  input logic [NA-1:0] mask_a,
  input logic          w1c,
  input logic          irq_hi
);
  localparam logic [NA-1:0] LVLM = NA'(1) << LVL_IDX;

  logic [NA-1:0] evt_q;
  logic [NA-1:0] edge_a;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_a;
  end
  assign edge_a = evt_a & ~evt_q;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (mask_a != '0)); // R8

  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_a & prio) & ~LVLM) & ~hi_view) == '0)); // R5

  AST_RC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd0 && !w1c)
    |=> (((hi_view & ~LVLM) & ~$past(edge_a & prio)) == '0)); // R3

  AST_W1C_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd0 && w1c)
    |=> ((($past(hi_view) & ~LVLM) & ~hi_view) == '0)); // R7

  AST_GB_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd2)
    |=> (bus_rdata == {{(DW-NB){1'b0}}, $past(b_view)})); // R4

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    prio[LVL_IDX] |-> (hi_view[LVL_IDX] == evt_a[LVL_IDX])); // R6
endmodule

bind irq_latch_agg irq_latch_agg_chk #(.NA(NA), .NB(NB), .DW(DW), .LVL_IDX(LVL_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .hi_view(hi_view), .b_view(b_view),
  .prio(prio), .mask_a(mask_a), .w1c(w1c), .irq_hi(irq_hi)
);

// File: tb/sim_irq_latch_agg.sv
`timescale 1ns/1ps
module sim_irq_latch_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_a = '0;
  logic [13:0] evt_b = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_hi, irq_lo, irq_grp;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_latch_agg u0 (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo), .irq_grp(irq_grp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse_a(input int ch);
    @(negedge clk); evt_a[ch] = 1'b1;
    @(negedge clk); evt_a[ch] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_hi", {31'd0, irq_hi}, 0);
    chk("R1 irq_lo", {31'd0, irq_lo}, 0);
    chk("R1 irq_grp", {31'd0, irq_grp}, 0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 0);
    end
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr(3, 32'h0000_00F0);
    wr(4, 32'hFFFF_FFFF);
    pulse_a(5); pulse_a(2);
    chk("R2 irq_hi set", {31'd0, irq_hi}, 1);
    chk("R2 irq_lo set", {31'd0, irq_lo}, 1);
    rd(0, d); chk("R3 read hi", d, 32'h20);
    rd(1, d); chk("R3 lo untouched by hi read", d, 32'h4);
    chk("R3 irq_hi cleared", {31'd0, irq_hi}, 0);
    chk("R3 irq_lo cleared", {31'd0, irq_lo}, 0);
    @(negedge clk); evt_a[3] = 1'b1;
    rd(1, d); chk("R2 held input latched", d, 32'h8);
    rd(1, d); chk("R2 held input not relatched", d, 0);
    @(negedge clk); evt_a[3] = 1'b0;
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(4, 0);
    pulse_a(5);
    chk("R8 masked irq_hi", {31'd0, irq_hi}, 0);
    wr(4, 32'h20);
    chk("R8 unmasked irq_hi", {31'd0, irq_hi}, 1);
    rd(0, d); chk("R8 latch under mask", d, 32'h20);
    wr(4, 32'hFFFF_FFFF);
  endtask

  task automatic t_groupb;
    logic [31:0] d;
    @(negedge clk); evt_b[13] = 1'b1;
    @(negedge clk); evt_b[13] = 1'b0;
    chk("R8 irq_grp masked", {31'd0, irq_grp}, 0);
    wr(5, 32'h2000);
    chk("R8 irq_grp unmasked", {31'd0, irq_grp}, 1);
    rd(2, d); chk("R4 read group b", d, 32'h2000);
    rd(2, d); chk("R4 group b cleared", d, 0);
    chk("R4 irq_grp low", {31'd0, irq_grp}, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    pulse_a(1);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd1; evt_a[0] = 1'b1;
    @(negedge clk); bus_rd = 1'b0; evt_a[0] = 1'b0;
    chk("R5 read data excludes new edge", bus_rdata, 32'h2);
    rd(1, d); chk("R5 new edge retained", d, 32'h1);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(3, 32'h8000_00F0);
    @(negedge clk); evt_a[31] = 1'b1;
    @(negedge clk);
    chk("R6 level drives irq_hi", {31'd0, irq_hi}, 1);
    rd(0, d); chk("R6 level read", d, 32'h8000_0000);
    rd(0, d); chk("R6 level not cleared by read", d, 32'h8000_0000);
    wr(3, 32'h0000_00F0);
    rd(1, d); chk("R6 level moves to low reg", d, 32'h8000_0000);
    @(negedge clk); evt_a[31] = 1'b0;
    rd(1, d); chk("R6 level follows input", d, 0);
    wr(3, 32'h8000_00F0);
    chk("R6 irq_hi low", {31'd0, irq_hi}, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(6, 1);
    pulse_a(4); pulse_a(6);
    rd(0, d); chk("R7 w1c read", d, 32'h50);
    rd(0, d); chk("R7 w1c read does not clear", d, 32'h50);
    wr(0, 32'h10);
    rd(0, d); chk("R7 w1c clears only written bit", d, 32'h40);
    @(negedge clk); evt_a[31] = 1'b1;
    wr(0, 32'h8000_0000);
    rd(0, d); chk("R7 level bit survives w1c", d, 32'h8000_0040);
    wr(6, 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R7 write ignored in read-clear mode", d, 32'h8000_0040);
    rd(0, d); chk("R3 edge bit cleared, level kept", d, 32'h8000_0000);
    @(negedge clk); evt_a[31] = 1'b0;
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(5, 32'hFFFF_FFFF);
    rd(5, d); chk("R9 mask b width", d, 32'h3FFF);
    wr(6, 32'hFFFF_FFFE);
    rd(6, d); chk("R9 ctrl bit0 only", d, 0);
    rd(3, d); chk("R9 prio readback", d, 32'h8000_00F0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route();
    t_mask();
    t_groupb();
    t_race();
    t_level();
    t_w1c();
    t_cfg();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule